// File: doc/BRIEF.md
# Memory Parity Error Supervisor

This block watches a vector of parity error flags coming from a processor's protected memories and turns them into one of two responses. Sources chosen as fatal start a fixed-length reset pulse toward the processor. Sources chosen as interrupting raise an interrupt line that stays high until software services it.

An error bit counts only on its rising edge. A flag that stays high does not fire again. For interrupting sources, each new edge sets a sticky pending bit. The interrupt output is the OR of the pending bits. Software reads the single status register through a small bus slave port. That read returns the pending bits and clears them in the same access.

The whole block runs on the bus clock and uses a synchronous active-low reset. Which bits are fatal and which interrupt is set by two parameter masks.

Top module: `perr_supervisor`

## Requirements
- R1: After reset, `irq`, `cpu_rst_o` and `ack_o` are low, and a status read returns zero.
- R2: Error bit assignment: bit 0 is the register file, bit 1 is the instruction cache data array, bit 2 is the instruction cache tag array, bit 3 is the data cache, and bit 4 is the translation buffers. A rising edge on a bit in `IRQ_MASK` (default 5'b00110) that is sampled at a clock edge makes `irq` high from the next cycle.
- R3: Once set, `irq` stays high while the error input is low again, until a status read.
- R4: An error bit held high across many cycles causes one event only. After a clearing read, it does not raise `irq` again.
- R5: A read at address 32'hE000_0000 returns the pending bits in data bits [4:0], with bit i set for source i. The upper bits are zero. The same access clears all pending bits, so `irq` is low in the cycle after the acknowledge.
- R6: A rising edge that arrives in the same cycle as a clearing read is not part of that read's data. It stays pending and keeps `irq` high.
- R7: A rising edge on a bit in `RESET_MASK` (default 5'b00001) drives `cpu_rst_o` high for exactly `RST_LEN` (default 16) consecutive cycles, starting from the next cycle.
- R8: A new reset-source edge during an active pulse restarts the count. The pulse then ends `RST_LEN` cycles after the last edge.
- R9: A rising edge on a bit that is in neither mask changes neither `irq` nor `cpu_rst_o`.
- R10: `ack_o` rises one cycle after a strobe with `cyc_i` and lasts one cycle. A write is acknowledged and changes nothing. A read at any other address returns zero and does not clear the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_vec | input | 5 | Parity error flags from the processor |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Write enable (writes are ignored) |
| adr_i | input | 32 | Byte address |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Cycle acknowledge |
| irq | output | 1 | Level interrupt, high while any bit is pending |
| cpu_rst_o | output | 1 | Reset pulse to the processor |

## Verification
The hardest case to reach is the one where a new error edge lands in the same clock as the read that clears the pending bits. The bench reaches it by raising the error bit on the same falling edge that starts the strobe. It then checks that the read data excludes the new bit and that a second read returns it. The bench also sweeps all 31 nonzero error patterns. For each pattern it computes the expected interrupt, read data and pulse length from the masks. A separate sequence re-triggers the reset pulse partway through to check that the count restarts.

// File: rtl/perr_pkg.sv
// Shared constants and helpers for the parity error supervisor.
// Assumes a 32-bit bus with byte addresses.
package perr_pkg;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 32;

    // Widen a pending vector to the bus data width, filling with zeros.
    function automatic logic [BUS_DW-1:0] zext(input logic [BUS_DW-1:0] v);
        return v;
    endfunction
endpackage

// File: rtl/perr_edge_det.sv
// Rising-edge finder: registers a copy of the error vector and flags
// bits that are high now but were low one clock earlier.
// Assumes err_vec is already synchronous to clk.
module perr_edge_det #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] err_vec,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Keep last cycle's error vector.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= err_vec;
    end

    assign rise = err_vec & ~prev_q;

    // R4
    held_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(err_vec) |-> (rise == '0));
endmodule

// File: rtl/perr_pending.sv
// Sticky pending register for interrupting sources. A clear removes the
// old bits, and edges in the same cycle are still captured.
// Assumes clr is a single-cycle pulse from the bus port.
module perr_pending #(
    parameter int unsigned W = 5,
    parameter logic [W-1:0] IRQ_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise,
    input  logic         clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] set_bits;
    assign set_bits = rise & IRQ_MASK;

    // Accumulate new edges; on clear keep only this cycle's edges.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= '0;
        else if (clr) pend <= set_bits;
        else          pend <= pend | set_bits;
    end

    // R2
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> (pend != '0));
    // R3
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend != '0) && !clr) |=> (pend != '0));
endmodule

// File: rtl/perr_rst_gen.sv
// Reset pulse generator: any trigger loads the counter with LEN, and the
// output stays high while the counter is nonzero.
// Assumes LEN >= 1.
module perr_rst_gen #(
    parameter int unsigned LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int unsigned CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);
    logic [CW-1:0] cnt_q;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trig)         cnt_q <= LOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q != '0);

    // R7
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse);
    // R8
    rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && !trig) |=> (cnt_q < LOAD));
endmodule

// File: rtl/perr_bus_port.sv
// Slave port: acknowledges one clock after strobe and returns the status
// word on a read hit. It raises a clear pulse on an accepted read hit.
// Assumes the master drops the strobe after seeing the acknowledge.
module perr_bus_port
    import perr_pkg::*;
#(
    parameter int unsigned W = 5,
    parameter logic [BUS_AW-1:0] REG_ADDR = 32'hE000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_i,
    input  logic              stb_i,
    input  logic              we_i,
    input  logic [BUS_AW-1:0] adr_i,
    input  logic [W-1:0]      pend,
    output logic [BUS_DW-1:0] dat_o,
    output logic              ack_o,
    output logic              clr
);
    logic take;
    assign take = cyc_i && stb_i && !ack_o;
    assign clr  = take && !we_i && (adr_i == REG_ADDR);

    // Single-cycle acknowledge and captured read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            dat_o <= '0;
        end else begin
            ack_o <= take;
            if (clr)       dat_o <= zext(BUS_DW'(pend));
            else if (take) dat_o <= '0;
        end
    end

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R10
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cyc_i && stb_i));
endmodule

// File: rtl/perr_supervisor.sv
// Top of the parity error supervisor. It turns rising edges on masked
// error bits into a held interrupt or a fixed-length processor reset.
// Assumes err_vec is synchronous to the bus clock.
module perr_supervisor #(
    parameter int unsigned ERR_W      = 5,
    parameter logic [ERR_W-1:0] RESET_MASK = 5'b00001,
    parameter logic [ERR_W-1:0] IRQ_MASK   = 5'b00110,
    parameter int unsigned RST_LEN    = 16,
    parameter logic [31:0] REG_ADDR   = 32'hE000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] err_vec,
    input  logic             cyc_i,
    input  logic             stb_i,
    input  logic             we_i,
    input  logic [31:0]      adr_i,
    output logic [31:0]      dat_o,
    output logic             ack_o,
    output logic             irq,
    output logic             cpu_rst_o
);
    logic [ERR_W-1:0] rise;
    logic [ERR_W-1:0] pend;
    logic             clr;
    logic             rst_trig;

    perr_edge_det #(.W(ERR_W)) u_edge (
        .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .rise(rise));

    perr_pending #(.W(ERR_W), .IRQ_MASK(IRQ_MASK)) u_pend (
        .clk(clk), .rst_n(rst_n), .rise(rise), .clr(clr), .pend(pend));

    assign rst_trig = |(rise & RESET_MASK);

    perr_rst_gen #(.LEN(RST_LEN)) u_rgen (
        .clk(clk), .rst_n(rst_n), .trig(rst_trig), .pulse(cpu_rst_o));

    perr_bus_port #(.W(ERR_W), .REG_ADDR(REG_ADDR)) u_port (
        .clk(clk), .rst_n(rst_n), .cyc_i(cyc_i), .stb_i(stb_i),
        .we_i(we_i), .adr_i(adr_i), .pend(pend), .dat_o(dat_o),
        .ack_o(ack_o), .clr(clr));

    assign irq = |pend;

    // R5
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(clr));
    // R9
    unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & (IRQ_MASK | RESET_MASK)) == '0 && !irq && !clr) |=> !irq);
endmodule

// File: tb/perr_supervisor_bench.sv
module perr_supervisor_bench;
    localparam logic [4:0] IRQ_M = 5'b00110;
    localparam logic [4:0] RST_M = 5'b00001;
    localparam int RLEN = 16;
    localparam logic [31:0] RA = 32'hE000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] err_vec = '0;
    logic cyc_i = 1'b0, stb_i = 1'b0, we_i = 1'b0;
    logic [31:0] adr_i = '0;
    logic [31:0] dat_o;
    logic ack_o, irq, cpu_rst_o;
    int n_chk = 0, n_bad = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    perr_supervisor u_perr_supervisor (
        .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .cyc_i(cyc_i),
        .stb_i(stb_i), .we_i(we_i), .adr_i(adr_i), .dat_o(dat_o),
        .ack_o(ack_o), .irq(irq), .cpu_rst_o(cpu_rst_o));

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bus access; leaves the read data in rd.
    task automatic access(input logic w, input logic [31:0] a, input string req);
        @(negedge clk);
        cyc_i = 1'b1; stb_i = 1'b1; we_i = w; adr_i = a;
        @(negedge clk);
        check(ack_o == 1'b1, req, ack_o, 1);
        rd = dat_o;
        cyc_i = 1'b0; stb_i = 1'b0; we_i = 1'b0;
        @(negedge clk);
        check(ack_o == 1'b0, req, ack_o, 0);
    endtask

    initial begin
        #4000000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!irq && !cpu_rst_o && !ack_o, "R1", {irq, cpu_rst_o, ack_o}, 0);
        access(1'b0, RA, "R1");
        check(rd == 0, "R1", rd, 0);

        // R2 R3 R5 R7 R9: sweep every nonzero error pattern
        for (int v = 1; v < 32; v++) begin
            int hi;
            logic exp_irq, exp_rst;
            exp_irq = ((v & IRQ_M) != 0);
            exp_rst = ((v & RST_M) != 0);
            @(negedge clk); err_vec = 5'(v);
            @(negedge clk); err_vec = '0;
            check(irq == exp_irq, exp_irq ? "R2" : "R9", irq, exp_irq);
            hi = 0;
            for (int c = 0; c < RLEN + 4; c++) begin
                if (cpu_rst_o) hi++;
                @(negedge clk);
            end
            check(hi == (exp_rst ? RLEN : 0), exp_rst ? "R7" : "R9", hi, exp_rst ? RLEN : 0);
            check(irq == exp_irq, "R3", irq, exp_irq);
            access(1'b0, RA, "R10");
            check(rd == 32'(v & IRQ_M), "R5", rd, v & IRQ_M);
            check(irq == 1'b0, "R5", irq, 0);
        end

        // R4 held level causes one event only
        @(negedge clk); err_vec = 5'b00010;
        @(negedge clk);
        check(irq == 1'b1, "R4", irq, 1);
        access(1'b0, RA, "R4");
        repeat (10) @(negedge clk);
        check(irq == 1'b0, "R4", irq, 0);
        err_vec = '0;

        // R10 write ignored, other address reads zero and keeps pending
        @(negedge clk); err_vec = 5'b00100;
        @(negedge clk); err_vec = '0;
        access(1'b1, RA, "R10");
        check(irq == 1'b1, "R10", irq, 1);
        access(1'b0, RA + 32'h4, "R10");
        check(rd == 0, "R10", rd, 0);
        check(irq == 1'b1, "R10", irq, 1);
        access(1'b0, RA, "R10");
        check(rd == 32'h4, "R5", rd, 4);

        // R6 edge in the same cycle as a clearing read
        @(negedge clk); err_vec = 5'b00010;
        @(negedge clk); err_vec = '0;
        @(negedge clk);
        cyc_i = 1'b1; stb_i = 1'b1; we_i = 1'b0; adr_i = RA; err_vec = 5'b00100;
        @(negedge clk);
        check(dat_o == 32'h2, "R6", dat_o, 2);
        check(irq == 1'b1, "R6", irq, 1);
        cyc_i = 1'b0; stb_i = 1'b0; err_vec = '0;
        access(1'b0, RA, "R6");
        check(rd == 32'h4, "R6", rd, 4);
        check(irq == 1'b0, "R6", irq, 0);

        // R8 retrigger restarts the count
        begin
            int hi;
            hi = 0;
            @(negedge clk); err_vec = 5'b00001;
            @(negedge clk); err_vec = '0; hi += cpu_rst_o;
            repeat (4) begin @(negedge clk); hi += cpu_rst_o; end
            err_vec = 5'b00001;
            @(negedge clk); err_vec = '0; hi += cpu_rst_o;
            repeat (RLEN + 4) begin @(negedge clk); hi += cpu_rst_o; end
            check(hi == RLEN + 5, "R8", hi, RLEN + 5);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule